// File: doc/BRIEF.md
# Instruction Window Pointer Controller

This block keeps track of which bank of a multi-bank instruction register file is live. Each function's window number rides in the top bits of its entry address. When a call is strobed, the block strips those bits off to form the jump address and selects the callee's window from the next cycle on. It also records the caller's return address and window on a small hardware stack. When a return is strobed, the block offers the most recent return address in the same cycle and puts the caller's window back in the next cycle.

Only one bank is live at any time. The block drives one power enable per window, and only the live window's enable is high, so the other banks can sit in a low-power state. The slot encoding is the same in every window: the pointer alone decides which bank the slot references reach.

Top module: `irwp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `win_o` is 0, `pwr_en_o` is 4'b0001, `ovf_o` and `unf_o` are 0, and the return stack is empty.
- R2: A call strobe alone (`call_i`=1, `ret_i`=0) sets `win_o` to `call_target_i[31:30]` one cycle later. In the same cycle as the strobe, `jump_addr_o` equals `call_target_i` with bits [31:30] cleared.
- R3: A call pushes `call_link_i` together with the `win_o` value in force at the strobe. The stack is last-in first-out.
- R4: A return strobe alone with a non-empty stack shows the newest saved return address on `ret_addr_o` in the same cycle. It pops that entry, and `win_o` takes the saved window one cycle later.
- R5: `pwr_en_o` always has exactly one bit set, at bit index `win_o`. It changes in the same cycle as `win_o`.
- R6: A call when 8 entries are held raises `ovf_o` one cycle later. The oldest entry is dropped, the new one is pushed, and the depth stays 8.
- R7: A return with an empty stack raises `unf_o` one cycle later and selects window 0. While such a strobe is applied, `ret_addr_o` reads 0.
- R8: If `call_i` and `ret_i` are high together, the strobe is ignored: the window, the stack and both flags are left unchanged.
- R9: `ovf_o` and `unf_o` are one-cycle pulses. They are 0 in the cycle after any strobe that did not overflow or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| call_target_i | input | 32 | Callee address; bits [31:30] hold its window |
| call_link_i | input | 32 | Return address to save on a call |
| jump_addr_o | output | 32 | Callee address with the window bits cleared |
| ret_addr_o | output | 32 | Newest saved return address, 0 when the stack is empty |
| win_o | output | 2 | Live window index |
| pwr_en_o | output | 4 | Per-window power enable, one-hot |
| ovf_o | output | 1 | Pulse: a call found the stack full |
| unf_o | output | 1 | Pulse: a return found the stack empty |

## Verification
The bench pushes nine frames into the eight-entry stack and then unwinds it. A design that dropped the newest frame instead of the oldest, or stalled the pointer, returns the wrong addresses or reports the underflow one return early or late. A return taken at reset, and one taken after full unwinding, check that the window falls to 0 and the address reads 0, not a stale frame. Simultaneous strobes check that a design which lets either one win changes the window or the stack, which later returns expose. Random call/return mixes compare the window, the one-hot enables and the flag pulses against a bench model every cycle.

// File: rtl/irwp_pkg.sv
// Shared types for the window pointer controller.
// Assumes: one strobe decode per cycle, consumed by the top module.
package irwp_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2,
        OP_BOTH = 2'd3
    } irwp_op_e;
endpackage

// File: rtl/irwp_addr_split.sv
// Splits a callee address into its window field (top bits) and a jump
// address with the window bits cleared.
// Assumes: the window field sits at the most significant WIN_W bits.
module irwp_addr_split #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_W  = 2
) (
    input  logic [ADDR_W-1:0] target_i,
    output logic [WIN_W-1:0]  win_o,
    output logic [ADDR_W-1:0] jump_o
);
    localparam int unsigned BODY_W = ADDR_W - WIN_W;

    // Separate window field from the address body.
    always_comb begin
        win_o  = target_i[ADDR_W-1 -: WIN_W];
        jump_o = {{WIN_W{1'b0}}, target_i[BODY_W-1:0]};
    end
endmodule

// File: rtl/irwp_ret_stack.sv
// Circular return stack holding {return address, caller window} frames.
// A push onto a full stack overwrites the oldest frame; a pop of an empty
// stack changes nothing and reports underflow.
// Assumes: DEPTH is a power of two so the write pointer wraps naturally.
module irwp_ret_stack #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_W  = 2,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [WIN_W-1:0]  push_win_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic [WIN_W-1:0]  top_win_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mem_addr [DEPTH];
    logic [WIN_W-1:0]  mem_win  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  top_ptr;
    logic [CNT_W-1:0]  count;

    // Status and newest-frame read port.
    always_comb begin
        empty_o    = (count == '0);
        full_o     = (count == CNT_MAX);
        top_ptr    = wr_ptr - PTR_W'(1);
        top_addr_o = empty_o ? '0 : mem_addr[top_ptr];
        top_win_o  = empty_o ? '0 : mem_win[top_ptr];
    end

    // Frame storage: written on push, no reset needed.
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_addr[wr_ptr] <= push_addr_i;
            mem_win[wr_ptr]  <= push_win_i;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (push_i) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
            if (!full_o) count <= count + CNT_W'(1);
        end else if (pop_i && !empty_o) begin
            wr_ptr <= wr_ptr - PTR_W'(1);
            count  <= count - CNT_W'(1);
        end
    end

    // R6: occupancy never exceeds the depth, even under repeated overflow.
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);

    // R6: a push on a full stack leaves it full.
    assert_full_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> full_o);

    // R7: popping an empty stack leaves it empty.
    assert_empty_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> empty_o);
endmodule

// File: rtl/irwp_pwr_decode.sv
// Turns the live window index into one power enable per bank.
// Assumes: NWIN equals 2**WIN_W.
module irwp_pwr_decode #(
    parameter int unsigned WIN_W = 2,
    parameter int unsigned NWIN  = 4
) (
    input  logic [WIN_W-1:0] win_i,
    output logic [NWIN-1:0]  pwr_en_o
);
    // One comparator per bank.
    for (genvar g = 0; g < NWIN; g++) begin : g_bank
        assign pwr_en_o[g] = (win_i == WIN_W'(g));
    end
endmodule

// File: rtl/irwp_ctrl.sv
// Window pointer controller: selects the live instruction register bank on
// calls and returns, saves and restores the caller's window on a return
// stack, and drives one-hot bank power enables.
// Assumes: strobes are single-cycle; both strobes together are ignored.
module irwp_ctrl #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_W  = 2,
    parameter int unsigned DEPTH  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  call_i,
    input  logic                  ret_i,
    input  logic [ADDR_W-1:0]     call_target_i,
    input  logic [ADDR_W-1:0]     call_link_i,
    output logic [ADDR_W-1:0]     jump_addr_o,
    output logic [ADDR_W-1:0]     ret_addr_o,
    output logic [WIN_W-1:0]      win_o,
    output logic [(1<<WIN_W)-1:0] pwr_en_o,
    output logic                  ovf_o,
    output logic                  unf_o
);
    import irwp_pkg::*;

    localparam int unsigned NWIN = 1 << WIN_W;

    irwp_op_e          op;
    logic [WIN_W-1:0]  tgt_win;
    logic [WIN_W-1:0]  top_win;
    logic              stk_empty;
    logic              stk_full;
    logic              do_push;
    logic              do_pop;

    // Decode the strobe pair into one operation.
    always_comb begin
        op      = irwp_op_e'({ret_i, call_i});
        do_push = (op == OP_CALL);
        do_pop  = (op == OP_RET);
    end

    irwp_addr_split #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_split (
        .target_i (call_target_i),
        .win_o    (tgt_win),
        .jump_o   (jump_addr_o)
    );

    irwp_ret_stack #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (do_push),
        .pop_i       (do_pop),
        .push_addr_i (call_link_i),
        .push_win_i  (win_o),
        .top_addr_o  (ret_addr_o),
        .top_win_o   (top_win),
        .empty_o     (stk_empty),
        .full_o      (stk_full)
    );

    irwp_pwr_decode #(.WIN_W(WIN_W), .NWIN(NWIN)) u_pwr (
        .win_i    (win_o),
        .pwr_en_o (pwr_en_o)
    );

    // Window pointer register and overflow/underflow pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_o <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            ovf_o <= do_push && stk_full;
            unf_o <= do_pop && stk_empty;
            if (do_push)
                win_o <= tgt_win;
            else if (do_pop)
                win_o <= stk_empty ? '0 : top_win;
        end
    end

    // R2: a lone call selects the window encoded in the target.
    assert_call_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i) |=> win_o == $past(call_target_i[ADDR_W-1 -: WIN_W]));

    // R4: a lone return on a non-empty stack restores the saved window.
    assert_ret_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !stk_empty) |=> win_o == $past(top_win));

    // R5: exactly one bank is powered, and it is the live one.
    assert_pwr_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pwr_en_o) == 1) && pwr_en_o[win_o]);

    // R7: an underflow pulse always comes with window 0.
    assert_unf_win0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> (win_o == '0));

    // R8: simultaneous strobes leave the window and flags quiet.
    assert_both_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> ($stable(win_o) && !ovf_o && !unf_o));

    // R9: the two flags never pulse together.
    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));
endmodule

// File: tb/irwp_ctrl_tb.sv
// Self-checking bench: directed corners plus seeded random call/return mix,
// compared against a bench-side stack model.
module irwp_ctrl_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic [31:0] call_target_i = '0;
    logic [31:0] call_link_i = '0;
    logic [31:0] jump_addr_o, ret_addr_o;
    logic [1:0]  win_o;
    logic [3:0]  pwr_en_o;
    logic        ovf_o, unf_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench model state.
    logic [31:0] m_addr [DEPTH];
    logic [1:0]  m_win  [DEPTH];
    int          m_cnt = 0;
    logic [1:0]  m_cur = 2'd0;
    logic        m_ovf = 1'b0;
    logic        m_unf = 1'b0;

    always #10 clk = ~clk;

    irwp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .call_target_i(call_target_i), .call_link_i(call_link_i),
        .jump_addr_o(jump_addr_o), .ret_addr_o(ret_addr_o), .win_o(win_o),
        .pwr_en_o(pwr_en_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    function automatic logic [31:0] exp_jump(logic [31:0] t);
        return {2'b00, t[29:0]};
    endfunction

    function automatic logic [3:0] exp_pwr(logic [1:0] w);
        return 4'b0001 << w;
    endfunction

    function automatic logic [31:0] exp_ret_addr();
        return (m_cnt > 0) ? m_addr[m_cnt-1] : 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one strobe at a negedge, check same-cycle outputs, then the
    // registered outputs at the following negedge.
    task automatic do_op(bit c, bit r, logic [31:0] tgt, logic [31:0] lnk);
        call_i = c; ret_i = r; call_target_i = tgt; call_link_i = lnk;
        #1;
        if (c && !r) check("R2 jump", jump_addr_o, exp_jump(tgt));
        if (r && !c) begin
            if (m_cnt > 0) check("R4 ret_addr", ret_addr_o, exp_ret_addr());
            else           check("R7 ret_addr empty", ret_addr_o, 32'd0);
        end
        @(posedge clk);
        m_ovf = 1'b0; m_unf = 1'b0;
        if (c && !r) begin
            if (m_cnt == DEPTH) begin
                m_ovf = 1'b1;
                for (int i = 0; i < DEPTH-1; i++) begin
                    m_addr[i] = m_addr[i+1];
                    m_win[i]  = m_win[i+1];
                end
                m_cnt = DEPTH - 1;
            end
            m_addr[m_cnt] = lnk;
            m_win[m_cnt]  = m_cur;
            m_cnt++;
            m_cur = tgt[31:30];
        end else if (r && !c) begin
            if (m_cnt > 0) begin
                m_cnt--;
                m_cur = m_win[m_cnt];
            end else begin
                m_unf = 1'b1;
                m_cur = 2'd0;
            end
        end
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0;
        check(c && r ? "R8 win" : (r ? "R4 win" : "R2 win"), 32'(win_o), 32'(m_cur));
        check("R5 pwr", 32'(pwr_en_o), 32'(exp_pwr(m_cur)));
        check(m_ovf ? "R6 ovf" : "R9 ovf", 32'(ovf_o), 32'(m_ovf));
        check(m_unf ? "R7 unf" : "R9 unf", 32'(unf_o), 32'(m_unf));
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20061023));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check("R1 win", 32'(win_o), 32'd0);
        check("R1 pwr", 32'(pwr_en_o), 32'h1);
        check("R1 ovf", 32'(ovf_o), 32'd0);
        check("R1 unf", 32'(unf_o), 32'd0);
        // R1/R7: stack empty after reset, return underflows.
        do_op(1'b0, 1'b1, 32'd0, 32'd0);
        // R3/R6: nine nested calls overflow once, then unwind in LIFO order.
        for (int i = 1; i <= 9; i++)
            do_op(1'b1, 1'b0, {2'(i), 30'(i * 32'h100)}, 32'h1000 + 32'(i));
        do_op(1'b0, 1'b0, 32'd0, 32'd0); // R9: flag drops after overflow
        for (int i = 0; i < 9; i++)
            do_op(1'b0, 1'b1, 32'd0, 32'd0); // ninth return underflows (R7)
        // R8: simultaneous strobes on a non-empty stack change nothing.
        do_op(1'b1, 1'b0, 32'hC000_0040, 32'hAAAA_0001);
        do_op(1'b1, 1'b1, 32'h4000_0080, 32'hBBBB_0002);
        do_op(1'b0, 1'b1, 32'd0, 32'd0);
        do_op(1'b0, 1'b1, 32'd0, 32'd0);
        // Random mix, biased toward calls so the stack fills.
        for (int n = 0; n < 400; n++) begin
            int unsigned sel = $urandom % 16;
            bit c = (sel < 8) || (sel == 15);
            bit r = (sel >= 8);
            do_op(c, r, $urandom, $urandom);
        end
        // R1: reset mid-run empties the stack.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_cur = 2'd0;
        check("R1 win after reset", 32'(win_o), 32'd0);
        do_op(1'b0, 1'b1, 32'd0, 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule